// File: doc/BRIEF.md
# Match-Compare Event Timer with Free-Running Timebase

This block is a register-mapped general-purpose timer for use as an operating-system event source beside a continuous timebase. An event counter advances on every cycle of a slow tick enable while its run bit is set. The counter is compared with a programmable match value. On a match it raises a one-cycle interrupt pulse. It can also return to zero by itself, which gives a periodic event. In one-shot use, software clears the run bit from its interrupt handler.

Clearing the event counter takes time. A write to the clear register raises a pending flag in a status register. The counter goes to zero only after two further slow ticks, which stand for synchronisation into the slow clock domain. Software polls the flag before it restarts the counter. A second counter of the same width runs from a fast reference enable. A small divider sits in front of it and is selected by a register. Once enabled, this counter serves as the monotonic timebase.

The host side is a single-cycle port. Writes take effect at the clock edge. Reads are combinational and return live values. All registers are 32-bit words. Addresses are byte addresses and must be word aligned.

Top module: `match_event_timer`

## Requirements
- R1: While reset is asserted, and right after it is released, every readable address returns 0 and irq_o is 0: match 0, both counters 0, both run bits off, no clear pending, divider select 0 (divide by one).
- R2: The match value sits at byte offset 0x00 and holds CNT_W bits, read back zero-extended. The control word sits at 0x08: bit 0 is the event run bit and bit 1 is clear-on-match. Its other bits read 0.
- R3: The event count reads at 0x04. It rises by exactly 1 on every clock edge where tick_en is 1 and the run bit is set, and it wraps modulo 2^CNT_W. It holds when the run bit is off. Writes to 0x04 do not change it.
- R4: A write of any data to 0x0C sets the pending flag, which is bit 10 of the status word at 0x10. On the second tick_en edge after the write, the event count becomes 0 and the flag returns to 0. Until then the flag stays 1, however many cycles pass without a tick. Reads of 0x0C return 0.
- R5: irq_o is high for exactly the one clock cycle that follows an edge where tick_en is 1, the run bit is set, the count equals the match value and no clear completes on that edge. It is 0 in all other cycles.
- R6: With clear-on-match set, a tick edge that finds the count equal to the match value loads 0 instead of incrementing, so the count never exceeds the match value and events come every match+1 ticks. With the bit clear, the count runs past the match value.
- R7: The timebase count reads at 0x14, and its enable is bit 0 of the word at 0x18. While enabled, it rises by 1 after every (select+1) ref_en edges, wraps modulo 2^CNT_W, and holds while disabled.
- R8: The divider select is bits [1:0] of the word at 0x1C. Value s divides ref_en by s+1, so value 3 divides by 4. A select that is lowered below the divider's current phase takes effect on the next ref_en edge.
- R9: Reads of offsets 0x20 and above, and of any address whose low two bits are not 00, return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW (6) | Byte address of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for bus_addr |
| tick_en | input | 1 | Slow tick enable that steps the event counter |
| ref_en | input | 1 | Fast reference enable that feeds the timebase divider |
| irq_o | output | 1 | One-cycle event interrupt pulse |

## Verification
The embedded properties check on every cycle that a stopped counter holds its value, that a completed clear leaves zero and that a clear write always raises the pending flag. They also check that clear-on-match reloads zero, that every interrupt pulse follows a matching tick, and that the timebase only ever steps by one and only while enabled. Some behaviour only the bench scenarios can show: the exact two-tick latency of a clear, the count of pulses over a whole one-shot or periodic run, wrapping at the counter width, the divide ratios for each select value, and the silence of unmapped and misaligned addresses. These scenarios are compared cycle by cycle against a behavioural model under random tick and reference patterns.

// File: rtl/met_pkg.sv
package met_pkg;
   // word indices (byte offset / 4) of the register file
   localparam int unsigned WI_MATCH  = 0;
   localparam int unsigned WI_COUNT  = 1;
   localparam int unsigned WI_CTRL   = 2;
   localparam int unsigned WI_CLEAR  = 3;
   localparam int unsigned WI_STATUS = 4;
   localparam int unsigned WI_TBCNT  = 5;
   localparam int unsigned WI_TBEN   = 6;
   localparam int unsigned WI_TBDIV  = 7;
   localparam int unsigned NUM_WORDS = 8;

   typedef struct packed {
      logic clr_on_match;   // control bit 1
      logic run;            // control bit 0
   } ctrl_t;
endpackage

// File: rtl/met_event_cnt.sv
module met_event_cnt #(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             run,
   input  logic             clr_on_match,
   input  logic [CNT_W-1:0] match,
   input  logic             clr_wr,
   output logic [CNT_W-1:0] cnt_o,
   output logic             pend_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             clr_done;
   logic             hit;

   assign hit = (cnt_q == match);

   // clear synchroniser: variant chosen by the number of slow ticks
   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         assign clr_done = pend_q && tick_en;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pend_q <= 1'b0;
            else if (clr_wr)           pend_q <= 1'b1;
            else if (clr_done)         pend_q <= 1'b0;
         end
      end else begin : g_sync_multi
         localparam int unsigned STG_W = $clog2(SYNC_STAGES);
         localparam logic [STG_W-1:0] LAST = STG_W'(SYNC_STAGES - 1);
         logic [STG_W-1:0] stage_q;
         assign clr_done = pend_q && tick_en && (stage_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q  <= 1'b0;
               stage_q <= '0;
            end else if (clr_wr) begin
               pend_q  <= 1'b1;
               stage_q <= '0;
            end else if (pend_q && tick_en) begin
               if (stage_q == LAST) pend_q  <= 1'b0;
               else                 stage_q <= stage_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr_done)          cnt_q <= '0;
      else if (tick_en && run)    cnt_q <= (clr_on_match && hit) ? '0 : cnt_q + 1'b1;
   end

   logic irq_raw;
   assign irq_raw = tick_en && run && hit && !clr_done;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq_o = irq_q;

         AST_IRQ_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q |-> $past(tick_en && run && (cnt_q == match))); // R5
      end else begin : g_irq_comb
         assign irq_o = irq_raw;
      end
   endgenerate

   assign cnt_o  = cnt_q;
   assign pend_o = pend_q;

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !pend_q) |=> $stable(cnt_q)); // R3
   AST_CLEAR_LEAVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> (cnt_q == '0)); // R4
   AST_MATCH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && run && clr_on_match && (cnt_q == match)) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/met_timebase.sv
module met_timebase #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic             enable,
   input  logic [DIV_W-1:0] div_sel,
   output logic [CNT_W-1:0] cnt_o
);
   logic [DIV_W-1:0] phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         cnt_q   <= '0;
      end else if (enable && ref_en) begin
         if (phase_q >= div_sel) begin
            phase_q <= '0;
            cnt_q   <= cnt_q + 1'b1;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;

   AST_TB_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_q) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R7
   AST_TB_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/match_event_timer.sv
module match_event_timer
   import met_pkg::*;
#(
   parameter int unsigned DW          = 32,
   parameter int unsigned AW          = 6,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned DIV_W       = 2,
   parameter int unsigned PEND_BIT    = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          tick_en,
   input  logic          ref_en,
   output logic          irq_o
);
   localparam int unsigned WIDX_W = AW - 2;

   generate
      if (AW < 5)              begin : g_bad_aw   $error("AW too small for register file"); end
      if (CNT_W < 2 || CNT_W > DW) begin : g_bad_cw $error("CNT_W out of range"); end
      if (DIV_W < 1 || DIV_W > 8)  begin : g_bad_dw $error("DIV_W out of range"); end
      if (PEND_BIT >= DW)      begin : g_bad_pb   $error("PEND_BIT outside data word"); end
      if (SYNC_STAGES < 1)     begin : g_bad_ss   $error("SYNC_STAGES must be at least 1"); end
   endgenerate

   logic              aligned;
   logic [WIDX_W-1:0] widx;
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign widx    = bus_addr[AW-1:2];

   function automatic logic sel_w(input logic [WIDX_W-1:0] w, input int unsigned idx);
      return (w == WIDX_W'(idx));
   endfunction

   logic wr_match, wr_ctrl, wr_clear, wr_tben, wr_tbdiv;
   assign wr_match = bus_wr && aligned && sel_w(widx, WI_MATCH);
   assign wr_ctrl  = bus_wr && aligned && sel_w(widx, WI_CTRL);
   assign wr_clear = bus_wr && aligned && sel_w(widx, WI_CLEAR);
   assign wr_tben  = bus_wr && aligned && sel_w(widx, WI_TBEN);
   assign wr_tbdiv = bus_wr && aligned && sel_w(widx, WI_TBDIV);

   logic [CNT_W-1:0] match_q;
   ctrl_t            ctrl_q;
   logic             tb_en_q;
   logic [DIV_W-1:0] div_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q   <= '0;
         ctrl_q    <= '0;
         tb_en_q   <= 1'b0;
         div_sel_q <= '0;
      end else begin
         if (wr_match) match_q   <= bus_wdata[CNT_W-1:0];
         if (wr_ctrl)  ctrl_q    <= bus_wdata[1:0];
         if (wr_tben)  tb_en_q   <= bus_wdata[0];
         if (wr_tbdiv) div_sel_q <= bus_wdata[DIV_W-1:0];
      end
   end

   logic [CNT_W-1:0] ev_cnt, tb_cnt;
   logic             ev_pend;

   met_event_cnt #(
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES),
      .IRQ_REG    (IRQ_REG)
   ) i_event (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .run         (ctrl_q.run),
      .clr_on_match(ctrl_q.clr_on_match),
      .match       (match_q),
      .clr_wr      (wr_clear),
      .cnt_o       (ev_cnt),
      .pend_o      (ev_pend),
      .irq_o       (irq_o)
   );

   met_timebase #(
      .CNT_W(CNT_W),
      .DIV_W(DIV_W)
   ) i_timebase (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_en (ref_en),
      .enable (tb_en_q),
      .div_sel(div_sel_q),
      .cnt_o  (tb_cnt)
   );

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (sel_w(widx, WI_MATCH))  bus_rdata[CNT_W-1:0] = match_q;
         if (sel_w(widx, WI_COUNT))  bus_rdata[CNT_W-1:0] = ev_cnt;
         if (sel_w(widx, WI_CTRL))   bus_rdata[1:0]       = ctrl_q;
         if (sel_w(widx, WI_STATUS)) bus_rdata[PEND_BIT]  = ev_pend;
         if (sel_w(widx, WI_TBCNT))  bus_rdata[CNT_W-1:0] = tb_cnt;
         if (sel_w(widx, WI_TBEN))   bus_rdata[0]         = tb_en_q;
         if (sel_w(widx, WI_TBDIV))  bus_rdata[DIV_W-1:0] = div_sel_q;
      end
   end

   AST_CLEAR_RAISES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clear |=> ev_pend); // R4
endmodule

// File: tb/test_match_event_timer.sv
`timescale 1ns/1ps
module test_match_event_timer;
   localparam int CW = 12;
   localparam int DW = 32;
   localparam int AW = 6;
   localparam int unsigned MSK = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          tick_en = 1'b0;
   logic          ref_en = 1'b0;
   logic          irq_o;

   always #2 clk = ~clk;   // 250 MHz

   match_event_timer #(.DW(DW), .AW(AW), .CNT_W(CW)) i_match_event_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
      .ref_en(ref_en), .irq_o(irq_o));

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done_flag = 0;
   string scen = "R1";

   // ---------------- behavioural reference model ----------------
   int unsigned m_match, m_cnt, m_tb, m_div, m_sel;
   bit m_run, m_com, m_pend, m_tben, m_irq, m_done, m_hit;
   int m_stage;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_match = 0; m_cnt = 0; m_tb = 0; m_div = 0; m_sel = 0;
         m_run = 0; m_com = 0; m_pend = 0; m_tben = 0; m_irq = 0; m_stage = 0;
      end else begin
         m_hit  = (m_cnt == m_match);
         m_done = m_pend && tick_en && (m_stage == 1);
         m_irq  = tick_en && m_run && m_hit && !m_done;
         if (m_done) m_cnt = 0;
         else if (tick_en && m_run) m_cnt = (m_com && m_hit) ? 0 : ((m_cnt + 1) & MSK);
         if (m_pend && tick_en) begin
            if (m_stage == 1) m_pend = 0; else m_stage = m_stage + 1;
         end
         if (m_tben && ref_en) begin
            if (m_div >= m_sel) begin m_div = 0; m_tb = (m_tb + 1) & MSK; end
            else m_div = m_div + 1;
         end
         if (bus_wr && bus_addr[1:0] == 2'b00) begin
            case (int'(bus_addr >> 2))
               0: m_match = bus_wdata & MSK;
               2: begin m_run = bus_wdata[0]; m_com = bus_wdata[1]; end
               3: begin m_pend = 1; m_stage = 0; end
               6: m_tben = bus_wdata[0];
               7: m_sel = bus_wdata[1:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [AW-1:0] a);
      if (a[1:0] != 2'b00) return 0;
      case (int'(a >> 2))
         0: return m_match;
         1: return m_cnt;
         2: return {30'd0, m_com, m_run};
         4: return m_pend ? 32'h400 : 32'h0;
         5: return m_tb;
         6: return {31'd0, m_tben};
         7: return m_sel;
         default: return 0;
      endcase
   endfunction

   function automatic string addr_tag(input logic [AW-1:0] a);
      if (!rst_n) return "R1";
      if (a[1:0] != 2'b00) return "R9";
      case (int'(a >> 2))
         0, 2: return "R2";
         1: return "R3";
         3, 4: return "R4";
         5, 6: return "R7";
         7: return "R8";
         default: return "R9";
      endcase
   endfunction

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done_flag) begin
         n_chk++;
         if (bus_rdata !== m_read(bus_addr)) begin
            n_bad++;
            $display("FAIL %s/%s rdata @0x%02h act=0x%08h exp=0x%08h",
                     scen, addr_tag(bus_addr), bus_addr, bus_rdata, m_read(bus_addr));
         end
         n_chk++;
         if (irq_o !== m_irq) begin
            n_bad++;
            $display("FAIL %s/R5 irq_o act=%0b exp=%0b", scen, irq_o, m_irq);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
      end
   endtask

   task automatic step(input bit t, input bit r);
      tick_en = t; ref_en = r;
      @(posedge clk); #1;
      bus_wr = 1'b0; tick_en = 1'b0; ref_en = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = 1'b0; ref_en = 1'b0;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
      bus_addr = a; #0.5; v = bus_rdata;
   endtask

   task automatic do_clear(input logic [31:0] d);
      wr(6'h0C, d); step(1, 0); step(1, 0);
   endtask

   task automatic finish_run();
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      logic [31:0] v, v0;
      int irqs;
      @(posedge clk); #1;
      for (int a = 0; a < 32; a += 4) begin rd(a[AW-1:0], v); chk("R1 reset read", v, 0); end
      repeat (3) step(1, 1);
      rst_n = 1'b1;
      rd(6'h10, v); chk("R1 status after reset", v, 0);
      rd(6'h1C, v); chk("R1 divider after reset", v, 0);

      scen = "R2";
      wr(6'h00, 32'hFFFF_FABC); rd(6'h00, v); chk("R2 match masked", v, 32'hABC);
      wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, v); chk("R2 ctrl bits", v, 3);
      wr(6'h08, 0);             rd(6'h08, v); chk("R2 ctrl off", v, 0);

      scen = "R3";
      wr(6'h00, 32'h800); wr(6'h08, 1);
      repeat (7) step(1, 0);
      step(0, 0);
      rd(6'h04, v); chk("R3 seven ticks", v, 7);
      wr(6'h08, 0); repeat (5) step(1, 0);
      rd(6'h04, v); chk("R3 hold when stopped", v, 7);
      wr(6'h04, 32'h123); rd(6'h04, v); chk("R3 count write ignored", v, 7);

      scen = "R4";
      wr(6'h0C, 32'hDEAD);
      rd(6'h10, v); chk("R4 pending set", v, 32'h400);
      rd(6'h0C, v); chk("R4 clear reads zero", v, 0);
      repeat (4) step(0, 0);
      rd(6'h10, v); chk("R4 pending waits for ticks", v, 32'h400);
      step(1, 0);
      rd(6'h10, v); chk("R4 pending after one tick", v, 32'h400);
      rd(6'h04, v); chk("R4 count before second tick", v, 7);
      step(1, 0);
      rd(6'h10, v); chk("R4 pending done", v, 0);
      rd(6'h04, v); chk("R4 count zero", v, 0);

      scen = "R5";
      wr(6'h00, 10); wr(6'h08, 1);
      irqs = 0;
      for (int i = 0; i < 30; i++) begin step(1, 0); if (irq_o) irqs++; end
      chk("R5 one pulse in one-shot run", irqs, 1);
      wr(6'h08, 0);

      scen = "R6";
      do_clear(0);
      wr(6'h00, 4); wr(6'h08, 3);
      irqs = 0;
      for (int i = 0; i < 50; i++) begin
         step(1, 0); if (irq_o) irqs++;
         rd(6'h04, v);
         if (v > 4) chk("R6 count above match", v, 4);
      end
      chk("R6 periodic pulses", irqs, 10);
      wr(6'h08, 1); repeat (9) step(1, 0);
      rd(6'h04, v); chk("R6 runs past match when off", v > 4, 1);

      scen = "R3";
      wr(6'h08, 0); do_clear(0);
      wr(6'h00, 32'h800); wr(6'h08, 1);
      repeat (4099) step(1, 0);
      rd(6'h04, v); chk("R3 wrap modulo 2^CNT_W", v, 3);
      wr(6'h08, 0);

      scen = "R7";
      wr(6'h18, 1);
      repeat (10) step(0, 1);
      rd(6'h14, v); chk("R7 divide by one", v, 10);
      wr(6'h18, 0); repeat (6) step(0, 1);
      rd(6'h14, v); chk("R7 hold when disabled", v, 10);
      scen = "R8";
      wr(6'h1C, 32'hFFFF_FFFF); rd(6'h1C, v); chk("R8 select field", v, 3);
      wr(6'h18, 1);
      repeat (20) step(0, 1);
      rd(6'h14, v); chk("R8 divide by four", v, 15);
      for (int s = 1; s < 3; s++) begin
         wr(6'h1C, s);
         rd(6'h14, v0);
         repeat (60) step(0, ($urandom_range(0, 2) != 0));
      end
      scen = "R7";
      wr(6'h1C, 0);
      rd(6'h14, v0);
      repeat (4096) step(0, 1);
      rd(6'h14, v); chk("R7 timebase wrap", v, v0);

      scen = "R9";
      for (int a = 32; a < 64; a += 4) begin rd(a[AW-1:0], v); chk("R9 unmapped read", v, 0); end
      rd(6'h01, v); chk("R9 misaligned read", v, 0);
      wr(6'h09, 3); rd(6'h08, v); chk("R9 misaligned write ignored", v, 0);
      wr(6'h20, 3); rd(6'h08, v); chk("R9 unmapped write ignored", v, 0);

      scen = "R6";
      wr(6'h00, 7); wr(6'h08, 3);
      for (int i = 0; i < 400; i++) begin
         if (i % 97 == 5) wr(6'h0C, i);
         else step(($urandom_range(0, 2) == 0), $urandom_range(0, 1) == 1);
         bus_addr = 6'(4 * $urandom_range(0, 8));
      end
      scen = "R5";
      wr(6'h08, 1);
      for (int i = 0; i < 300; i++) begin
         step($urandom_range(0, 1) == 1, 1'b0);
         bus_addr = 6'h04;
      end
      step(0, 0);
      finish_run();
   end
endmodule